// File: doc/BRIEF.md
# Word-Counted Command/Data Channel Front End

This block sits between a 16-bit maintenance input channel, a 16-bit output channel and the registers that a command decoder reads. One down-counter decides what each arriving word means. While the counter is zero, the word is a command and goes into the command register. While the counter is nonzero, the word is data. Data words are packed into a 32-bit input register. The counter drops by one for each data word.

A count command reloads the counter. If the 32-bit output register has been loaded since the last transfer, the count applies to the output channel instead. The block then streams that many 16-bit words out, and may end with a one-cycle record pulse. A segment-load mode keeps every data word in the low half of the input register. A width select picks between alternating halves and low-half-only output.

Both handshakes are four-phase request/acknowledge. The incoming request and acknowledge lines pass through two-flop synchronizers before the block uses them.

Top module: `wcc_channel`

## Requirements
- R1: While the word counter is zero, an accepted input word is written to `cmd_reg`. If the word is not a count command, the counter stays zero and the next word is again a command.
- R2: A count command has `in_word[15:10]` equal to 6'o17. With bit 9 clear (short form), `in_word[5:0]`, zero-extended, is loaded into the counter.
- R3: With bit 9 set (long form), the next accepted word is loaded into the counter. That word is not written to `cmd_reg`, which keeps the count command.
- R4: While the counter is nonzero, each accepted word is data and decrements the counter. The first data word after any count load goes to `in_reg[31:16]`, the next to `in_reg[15:0]`, and so on, alternating.
- R5: While `seg_mode` is high, every data word is written to `in_reg[15:0]` and `in_reg[31:16]` is left unchanged.
- R6: Once the data count has run down to zero, the next accepted word is treated as a command.
- R7: A pulse on `out_load` captures `out_data` and marks output as pending. The next count command then sets the number of words to send on the output channel. While that transfer runs, no input word is acknowledged.
- R8: With `wide_out` high, output words come from bits 31:16 first and then alternate halves. With `wide_out` low, every output word comes from bits 15:0. `out_word` is stable while `out_req` is high.
- R9: If bit 8 of the count command was set, `out_record` pulses high for exactly one cycle after the last output word's handshake completes. If bit 8 was clear, `out_record` does not pulse.
- R10: After an output transfer finishes, the pending mark is cleared, so the next count command counts input data again.
- R11: After reset, `in_ack`, `out_req` and `out_record` are low, and `cmd_reg` and `in_reg` are zero. `in_ack` rises only while `in_req` is held high and falls after `in_req` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Input word request (asynchronous, synchronized inside) |
| in_word | input | 16 | Input channel word, stable while `in_req` is high |
| in_ack | output | 1 | Input word acknowledge |
| seg_mode | input | 1 | Segment-load mode: data words go to the low half only |
| wide_out | input | 1 | Output interface width: 1 = 32-bit, 0 = 16-bit |
| out_data | input | 32 | Value captured into the output register |
| out_load | input | 1 | Load strobe for the output register |
| out_req | output | 1 | Output word request |
| out_word | output | 16 | Output channel word |
| out_ack | input | 1 | Output word acknowledge (asynchronous, synchronized inside) |
| out_record | output | 1 | One-cycle end-of-transfer record pulse |
| cmd_reg | output | 16 | Command register |
| in_reg | output | 32 | Assembled input register |

## Verification
The properties assume a well-behaved partner on each channel. The sender holds `in_req` and `in_word` steady until it sees `in_ack`, and the receiver holds `out_ack` until `out_req` drops. The properties also assume that `out_load`, `seg_mode` and `wide_out` change only while no transfer is in progress. The directed tasks keep to this: each one drives a full four-phase exchange and waits on the opposite signal before moving on. Mode inputs and `out_load` are changed only between scenarios. The one deliberate violation is a request raised during an output transfer, and it is withdrawn before the transfer ends.

// File: rtl/wcc_pkg.sv
// Shared types and command field positions for the word-counted channel.
// Assumes a 16-bit command word whose top six bits carry the opcode.
package wcc_pkg;
    typedef enum logic [2:0] {
        ST_CMD   = 3'd0,   // counter zero, next word is a command
        ST_CNT   = 3'd1,   // next word is a long count
        ST_IN    = 3'd2,   // counter nonzero, words are data
        ST_OSEND = 3'd3,   // output request raised
        ST_OWAIT = 3'd4    // waiting for output acknowledge to fall
    } wcc_state_e;

    localparam int          OPC_HI    = 15;
    localparam int          OPC_LO    = 10;
    localparam logic [5:0]  OPC_COUNT = 6'o17;
    localparam int          LONG_BIT  = 9;
    localparam int          REC_BIT   = 8;
    localparam int          SHORT_W   = 6;
endpackage

// File: rtl/wcc_sync.sv
// Multi-stage flop synchronizer for a bus of independent level signals.
// Assumes each bit is a slow level (handshake), so no bus coherency is needed.
module wcc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wcc_counter.sv
// Synchronous loadable down counter with zero and one detection.
// Assumes load and dec are never both requested in one cycle; load wins.
module wcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero,
    output logic         last
);
    // counter register: load, decrement or hold
    always_ff @(posedge clk) begin
        if (!rst_n)           count <= '0;
        else if (load)        count <= load_val;
        else if (dec && !zero) count <= count - W'(1);
    end

    assign zero = (count == '0);
    assign last = (count == W'(1));
endmodule

// File: rtl/wcc_channel.sv
// Top of the word-counted command/data channel. One down counter steers
// input words to the command register or the 32-bit input register and
// meters output words taken from the output register.
// Assumes out_load, seg_mode and wide_out change only while idle, and that
// partners hold request/data (or acknowledge) until the other side answers.
module wcc_channel #(
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_req,
    input  logic [DW-1:0]   in_word,
    output logic            in_ack,
    input  logic            seg_mode,
    input  logic            wide_out,
    input  logic [2*DW-1:0] out_data,
    input  logic            out_load,
    output logic            out_req,
    output logic [DW-1:0]   out_word,
    input  logic            out_ack,
    output logic            out_record,
    output logic [DW-1:0]   cmd_reg,
    output logic [2*DW-1:0] in_reg
);
    import wcc_pkg::*;

    localparam int RW = 2 * DW;

    wcc_state_e    state;
    logic          req_s, ack_s;
    logic          in_ack_q, hi_half, out_flag, rec_en, record_q;
    logic [RW-1:0] out_reg_q;
    logic          accept, is_count, is_long;
    logic          cnt_load, cnt_dec, cnt_zero, cnt_last;
    logic [CW-1:0] cnt_val, cnt_q, short_val, long_val;

    wcc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({in_req, out_ack}),
        .q     ({req_s, ack_s})
    );

    assign accept    = req_s && !in_ack_q &&
                       (state == ST_CMD || state == ST_CNT || state == ST_IN);
    assign is_count  = (in_word[OPC_HI:OPC_LO] == OPC_COUNT);
    assign is_long   = in_word[LONG_BIT];
    assign short_val = {{(CW-SHORT_W){1'b0}}, in_word[SHORT_W-1:0]};
    assign long_val  = CW'(in_word);

    // counter control derived from the current state and handshakes
    always_comb begin
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = short_val;
        unique case (state)
            ST_CMD:   cnt_load = accept && is_count && !is_long;
            ST_CNT:   begin cnt_load = accept; cnt_val = long_val; end
            ST_IN:    cnt_dec  = accept;
            ST_OSEND: cnt_dec  = ack_s;
            default:  ;
        endcase
    end

    wcc_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .count    (cnt_q),
        .zero     (cnt_zero),
        .last     (cnt_last)
    );

    // input acknowledge: set on accept, cleared once request is released
    always_ff @(posedge clk) begin
        if (!rst_n)      in_ack_q <= 1'b0;
        else if (accept) in_ack_q <= 1'b1;
        else if (!req_s) in_ack_q <= 1'b0;
    end

    // sequencing, register writes and output metering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            cmd_reg   <= '0;
            in_reg    <= '0;
            hi_half   <= 1'b1;
            out_flag  <= 1'b0;
            rec_en    <= 1'b0;
            record_q  <= 1'b0;
            out_reg_q <= '0;
        end else begin
            record_q <= 1'b0;
            unique case (state)
                ST_CMD: if (accept) begin
                    cmd_reg <= in_word;
                    if (is_count) begin
                        hi_half <= 1'b1;
                        rec_en  <= in_word[REC_BIT];
                        if (is_long)
                            state <= ST_CNT;
                        else if (short_val != '0)
                            state <= out_flag ? ST_OSEND : ST_IN;
                    end
                end
                ST_CNT: if (accept) begin
                    if (long_val == '0) state <= ST_CMD;
                    else                state <= out_flag ? ST_OSEND : ST_IN;
                end
                ST_IN: if (accept) begin
                    if (seg_mode)     in_reg[DW-1:0]  <= in_word;
                    else if (hi_half) in_reg[RW-1:DW] <= in_word;
                    else              in_reg[DW-1:0]  <= in_word;
                    hi_half <= !hi_half;
                    if (cnt_last) state <= ST_CMD;
                end
                ST_OSEND: if (ack_s) begin
                    hi_half <= !hi_half;
                    state   <= ST_OWAIT;
                end
                ST_OWAIT: if (!ack_s) begin
                    if (cnt_zero) begin
                        state    <= ST_CMD;
                        out_flag <= 1'b0;
                        record_q <= rec_en;
                    end else begin
                        state <= ST_OSEND;
                    end
                end
                default: state <= ST_CMD;
            endcase
            if (out_load) begin
                out_reg_q <= out_data;
                out_flag  <= 1'b1;
            end
        end
    end

    assign in_ack     = in_ack_q;
    assign out_req    = (state == ST_OSEND);
    assign out_word   = (wide_out && hi_half) ? out_reg_q[RW-1:DW] : out_reg_q[DW-1:0];
    assign out_record = record_q;
endmodule

// File: rtl/wcc_channel_chk.sv
// Property checker for wcc_channel, attached by bind. Assumes well-behaved
// handshake partners as described in the brief.
module wcc_channel_chk (
    input logic                clk,
    input logic                rst_n,
    input wcc_pkg::wcc_state_e state,
    input logic                cnt_zero,
    input logic                in_req,
    input logic                in_ack,
    input logic                out_req,
    input logic [15:0]         out_word,
    input logic                out_record
);
    import wcc_pkg::*;

    // commands are only taken with an empty counter
    p_cmd_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> cnt_zero);

    // data reception implies a live count
    p_data_needs_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IN) |-> !cnt_zero);

    // no new input acknowledge while an output transfer runs
    p_no_ack_during_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OSEND || state == ST_OWAIT) &&
         ($past(state) == ST_OSEND || $past(state) == ST_OWAIT)) |-> !$rose(in_ack));

    // output word held while requested
    p_out_word_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && $past(out_req)) |-> $stable(out_word));

    // record is a single-cycle pulse
    p_record_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_record |=> !out_record);

    // record only follows the end of an output handshake
    p_record_after_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_record |-> ($past(state) == ST_OWAIT));

    // acknowledge answers a held request
    p_ack_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(in_req));
endmodule

bind wcc_channel wcc_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cnt_zero   (cnt_zero),
    .in_req     (in_req),
    .in_ack     (in_ack),
    .out_req    (out_req),
    .out_word   (out_word),
    .out_record (out_record)
);

// File: tb/wcc_channel_tb.sv
// Directed bench for wcc_channel: one task per scenario, each checking itself.
module wcc_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_req = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_ack;
    logic        seg_mode = 1'b0;
    logic        wide_out = 1'b1;
    logic [31:0] out_data = '0;
    logic        out_load = 1'b0;
    logic        out_req;
    logic [15:0] out_word;
    logic        out_ack = 1'b0;
    logic        out_record;
    logic [15:0] cmd_reg;
    logic [31:0] in_reg;

    int checks = 0;
    int errors = 0;
    int rec_count = 0;

    always #10 clk = ~clk;

    wcc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_word(in_word), .in_ack(in_ack),
        .seg_mode(seg_mode), .wide_out(wide_out), .out_data(out_data), .out_load(out_load),
        .out_req(out_req), .out_word(out_word), .out_ack(out_ack), .out_record(out_record),
        .cmd_reg(cmd_reg), .in_reg(in_reg)
    );

    always @(negedge clk) if (out_record) rec_count++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        in_word = w;
        in_req  = 1'b1;
        while (!in_ack) @(negedge clk);
        in_req = 1'b0;
        while (in_ack) @(negedge clk);
    endtask

    task automatic recv_word(output logic [15:0] w);
        while (!out_req) @(negedge clk);
        w = out_word;
        out_ack = 1'b1;
        while (out_req) @(negedge clk);
        out_ack = 1'b0;
    endtask

    task automatic load_out(input logic [31:0] v);
        @(negedge clk);
        out_data = v;
        out_load = 1'b1;
        @(negedge clk);
        out_load = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 in_ack reset", 32'(in_ack), 32'h0);
        check("R11 out_req reset", 32'(out_req), 32'h0);
        check("R11 out_record reset", 32'(out_record), 32'h0);
        check("R11 cmd_reg reset", 32'(cmd_reg), 32'h0);
        check("R11 in_reg reset", in_reg, 32'h0);
    endtask

    task automatic t_plain_commands;
        send_word(16'h1234);
        check("R1 first command", 32'(cmd_reg), 32'h1234);
        send_word(16'h0456);
        check("R1 second command", 32'(cmd_reg), 32'h0456);
        check("R1 in_reg untouched", in_reg, 32'h0);
    endtask

    task automatic t_short_count;
        send_word(16'h3C02);               // count opcode, short, count 2
        check("R2 count cmd stored", 32'(cmd_reg), 32'h3C02);
        send_word(16'hAAAA);
        send_word(16'h5555);
        check("R4 two halves", in_reg, 32'hAAAA5555);
        check("R2 data not in cmd_reg", 32'(cmd_reg), 32'h3C02);
        send_word(16'h0101);
        check("R6 command after count", 32'(cmd_reg), 32'h0101);
    endtask

    task automatic t_odd_count;
        send_word(16'h3C03);
        send_word(16'h0001);
        send_word(16'h0002);
        send_word(16'h0003);
        check("R4 odd count alternation", in_reg, 32'h00030002);
        send_word(16'h3C01);
        send_word(16'h7777);
        check("R4 half restarts at high", in_reg, 32'h77770002);
    endtask

    task automatic t_seg_mode;
        seg_mode = 1'b1;
        send_word(16'h3C02);
        send_word(16'h1111);
        check("R5 seg first word low", in_reg, 32'h77771111);
        send_word(16'h2222);
        check("R5 seg second word low", in_reg, 32'h77772222);
        seg_mode = 1'b0;
    endtask

    task automatic t_long_count;
        send_word(16'h3E00);               // count opcode, long form
        send_word(16'h0002);
        check("R3 cmd_reg keeps long cmd", 32'(cmd_reg), 32'h3E00);
        send_word(16'hBEEF);
        send_word(16'hCAFE);
        check("R3 long count data", in_reg, 32'hBEEFCAFE);
        send_word(16'h0202);
        check("R6 command after long count", 32'(cmd_reg), 32'h0202);
    endtask

    task automatic t_out_wide;
        logic [15:0] w;
        int rc;
        wide_out = 1'b1;
        load_out(32'h12345678);
        rc = rec_count;
        send_word(16'h3D02);               // short count 2, record bit
        in_word = 16'h9999;
        in_req  = 1'b1;
        repeat (10) @(negedge clk);
        check("R7 no ack during output", 32'(in_ack), 32'h0);
        in_req = 1'b0;
        repeat (4) @(negedge clk);
        recv_word(w);
        check("R8 wide first high", 32'(w), 32'h1234);
        recv_word(w);
        check("R8 wide second low", 32'(w), 32'h5678);
        repeat (8) @(negedge clk);
        check("R9 record pulse once", 32'(rec_count - rc), 32'h1);
        check("R7 cmd_reg unchanged by blocked word", 32'(cmd_reg), 32'h3D02);
    endtask

    task automatic t_out_narrow;
        logic [15:0] w;
        int rc;
        wide_out = 1'b0;
        load_out(32'h9ABCDEF0);
        rc = rec_count;
        send_word(16'h3C03);               // no record bit
        for (int i = 0; i < 3; i++) begin
            recv_word(w);
            check("R8 narrow low half", 32'(w), 32'hDEF0);
        end
        repeat (8) @(negedge clk);
        check("R9 no record without bit", 32'(rec_count - rc), 32'h0);
        wide_out = 1'b1;
    endtask

    task automatic t_after_output;
        send_word(16'h3C01);
        send_word(16'h4242);
        check("R10 count goes to input again", in_reg, 32'h4242CAFE);
        check("R10 no output request", 32'(out_req), 32'h0);
    endtask

    task automatic t_long_out;
        logic [15:0] w;
        int rc;
        load_out(32'h0F0F1E1E);
        rc = rec_count;
        send_word(16'h3F00);               // long form with record bit
        send_word(16'h0001);
        recv_word(w);
        check("R7 long count output word", 32'(w), 32'h0F0F);
        repeat (8) @(negedge clk);
        check("R9 record after long output", 32'(rec_count - rc), 32'h1);
        check("R3 count word kept out of cmd_reg", 32'(cmd_reg), 32'h3F00);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_commands();
        t_short_count();
        t_odd_count();
        t_seg_mode();
        t_long_count();
        t_out_wide();
        t_out_narrow();
        t_after_output();
        t_long_out();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule